// File: doc/BRIEF.md
# Non-Uniform Stack Interleave Mapper

This block maps a flat byte address onto four memory stacks whose populated capacities may differ. Each stack reports its capacity as a count of 1 MB chunks. A pulse on `cfg_start` latches those counts. A small sequential engine then builds up to four interleave tiers, one per clock. Each tier takes the smallest capacity still left among the live stacks and spreads that share round-robin across every live stack. The first tier therefore covers the lowest part of the address space across all populated stacks. Later tiers cover the higher addresses across fewer stacks, until every stack is used up.

Once `cfg_done` is high, the translator accepts one address per cycle through a valid/ready handshake. Two cycles later it returns the stack index and the byte offset inside that stack. The interleave unit is a 16-byte line, and the low four address bits pass straight through into the offset. A tier of three stacks needs a true divide by three, not a bit slice, so the second stage has a constant divider for each possible stack count. Addresses at or beyond the total capacity are flagged as out of range.

The engine has three states:
- `CFG_IDLE` is the state after reset.
- `CFG_BUILD` writes one tier per cycle.
- `CFG_READY` is the state in which the tiers are valid.

Its transitions are:
- IDLE→BUILD on a start pulse.
- BUILD→BUILD while live stacks remain after the current step, and on a new start pulse.
- BUILD→READY when the current step uses up the last live stack, or when no stack was populated.
- READY→BUILD on a new start pulse.

Top module: `stack_ilv_mapper`

## Requirements
- R1: After reset, `cfg_done`, `in_ready` and `out_valid` are 0.
- R2: After `cfg_start` falls, `cfg_done` rises after one cycle per distinct nonzero tier step, and after one cycle if all capacities are zero. It never takes more than 4 cycles. `in_ready` stays 0 until `cfg_done` is 1, and requests presented before then produce no output.
- R3: Below 4×min(capacity) MB, with all four stacks populated, line L (address bits [31:4]) goes to stack L mod 4 at byte offset (L div 4)×16.
- R4: In a later tier, let the relative line be the line index minus the tier base. Its remainder modulo the number of live stacks picks the n-th live stack in ascending index order. The offset is that stack's capacity consumed by earlier tiers, plus the quotient times 16.
- R5: Address bits [3:0] appear unchanged in `out_offset[3:0]` for every in-range address.
- R6: A stack whose capacity is zero is never returned for an in-range address.
- R7: An address at or above the total capacity (sum of capacities × 2^20) returns `out_oor`=1 with `out_stack`=0 and `out_offset`=0.
- R8: A request accepted at a clock edge appears with `out_valid`=1 exactly two edges later, and not after one edge. Back-to-back requests stream at one per cycle.
- R9: A `cfg_start` pulse discards requests still in the pipeline, drops `cfg_done`, and clears all tiers. The tiers are rebuilt from the newly latched capacities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Latch capacities and rebuild the tiers |
| cap_i | input | 32 | Four 8-bit capacities in MB; stack i at bits [8i+7:8i] |
| cfg_done | output | 1 | Tier table is valid |
| in_valid | input | 1 | Address request valid |
| in_ready | output | 1 | Request accepted when high with `in_valid` |
| in_addr | input | 32 | Byte address to translate |
| out_valid | output | 1 | Result valid |
| out_stack | output | 2 | Selected stack index |
| out_offset | output | 28 | Byte offset within the selected stack |
| out_oor | output | 1 | Address beyond total capacity |

## Verification
The first configuration has equal-prefix stacks of 64, 64, 64 and 32 MB. It separates the 4-way bit-slice region from the 3-way region above 128 MB, where quotient and remainder come from a true divide by three. The lines checked there include the very last one. The second configuration populates only stacks 1 and 3, which exposes an engine or picker that counts empty stacks as participants. A configuration with all stacks empty shows that everything falls out of range. Random capacities, including zeros, then produce three- and four-tier layouts and addresses on both sides of the total. Some of these are streamed back to back, which tells a correct two-stage pipeline apart from one that drops or repeats results.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        CFG_IDLE  = 2'd0,
        CFG_BUILD = 2'd1,
        CFG_READY = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/ilv_cfg_engine.sv
module ilv_cfg_engine
    import ilv_pkg::*;
#(
    parameter int NSTK  = 4,
    parameter int CAP_W = 8,
    parameter int SEL_W = 2,
    parameter int TB_W  = 10
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_start,
    input  logic [NSTK-1:0][CAP_W-1:0]                cap_i,
    output logic                                      cfg_done,
    output logic [NSTK-1:0]                           tier_vld,
    output logic [NSTK-1:0][TB_W-1:0]                 tier_base,
    output logic [NSTK-1:0][TB_W-1:0]                 tier_size,
    output logic [NSTK-1:0][NSTK-1:0]                 tier_mask,
    output logic [NSTK-1:0][NSTK-1:0][CAP_W-1:0]      tier_off,
    output logic [NSTK-1:0][CAP_W-1:0]                cap_q
);
    cfg_state_e state_q, state_d;

    logic [NSTK-1:0][CAP_W-1:0] rem_q, used_q;
    logic [TB_W-1:0]            base_q;
    logic [SEL_W-1:0]           tcnt_q;

    logic [NSTK-1:0]  live, left_after;
    logic [SEL_W:0]   n_live;
    logic [CAP_W-1:0] m_min;
    logic [TB_W-1:0]  step_span;
    logic             tier_step;

    always_comb begin
        m_min = '1;
        for (int i = 0; i < NSTK; i++) begin
            live[i] = (rem_q[i] != '0);
            if (live[i] && rem_q[i] < m_min) m_min = rem_q[i];
        end
        for (int i = 0; i < NSTK; i++) begin
            left_after[i] = live[i] && (rem_q[i] != m_min);
        end
        n_live    = (SEL_W+1)'($countones(live));
        step_span = TB_W'(m_min) * TB_W'(n_live);
        tier_step = (state_q == CFG_BUILD) && !cfg_start && (live != '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE:  if (cfg_start) state_d = CFG_BUILD;
            CFG_BUILD: begin
                if (cfg_start)                              state_d = CFG_BUILD;
                else if (live == '0 || left_after == '0)    state_d = CFG_READY;
            end
            CFG_READY: if (cfg_start) state_d = CFG_BUILD;
            default:   state_d = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || cfg_start) begin
            rem_q     <= rst_n ? cap_i : '0;
            cap_q     <= rst_n ? cap_i : '0;
            used_q    <= '0;
            base_q    <= '0;
            tcnt_q    <= '0;
            tier_vld  <= '0;
            tier_base <= '0;
            tier_size <= '0;
            tier_mask <= '0;
            tier_off  <= '0;
        end else if (tier_step) begin
            tier_vld[tcnt_q]  <= 1'b1;
            tier_base[tcnt_q] <= base_q;
            tier_size[tcnt_q] <= step_span;
            tier_mask[tcnt_q] <= live;
            tier_off[tcnt_q]  <= used_q;
            for (int i = 0; i < NSTK; i++) begin
                if (live[i]) begin
                    rem_q[i]  <= rem_q[i] - m_min;
                    used_q[i] <= used_q[i] + m_min;
                end
            end
            base_q <= base_q + step_span;
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    always_comb begin
        cfg_done = (state_q == CFG_READY);
    end

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done && !cfg_start |=> cfg_done); // R2
    AST_TIER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tier_step && tcnt_q == SEL_W'(NSTK-1) |-> left_after == '0); // R2
    AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_done && tier_vld == '0); // R9
endmodule

// File: rtl/ilv_tier_lookup.sv
module ilv_tier_lookup #(
    parameter int NSTK     = 4,
    parameter int CAP_W    = 8,
    parameter int TB_W     = 10,
    parameter int ADDR_W   = 32,
    parameter int CHUNK_LG = 20,
    parameter int LINE_LG  = 4,
    parameter int REL_W    = 26
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 flush,
    input  logic                                 in_fire,
    input  logic [ADDR_W-1:0]                    in_addr,
    input  logic [NSTK-1:0]                      tier_vld,
    input  logic [NSTK-1:0][TB_W-1:0]            tier_base,
    input  logic [NSTK-1:0][TB_W-1:0]            tier_size,
    input  logic [NSTK-1:0][NSTK-1:0]            tier_mask,
    input  logic [NSTK-1:0][NSTK-1:0][CAP_W-1:0] tier_off,
    output logic                                 s1_vld,
    output logic                                 s1_oor,
    output logic [REL_W-1:0]                     s1_rel,
    output logic [NSTK-1:0]                      s1_mask,
    output logic [NSTK-1:0][CAP_W-1:0]           s1_off,
    output logic [LINE_LG-1:0]                   s1_nib
);
    localparam int IDX_W = ADDR_W - CHUNK_LG;
    localparam int CMP_W = ((IDX_W > TB_W) ? IDX_W : TB_W) + 1;

    logic [IDX_W-1:0]              chunk;
    logic [NSTK-1:0]               hit;
    logic [TB_W-1:0]               sel_base;
    logic [NSTK-1:0]               sel_mask;
    logic [NSTK-1:0][CAP_W-1:0]    sel_off;
    logic [REL_W-1:0]              rel;

    always_comb begin
        chunk    = in_addr[ADDR_W-1:CHUNK_LG];
        sel_base = '0;
        sel_mask = '0;
        sel_off  = '0;
        for (int t = 0; t < NSTK; t++) begin
            hit[t] = tier_vld[t]
                  && (CMP_W'(chunk) >= CMP_W'(tier_base[t]))
                  && (CMP_W'(chunk) <  CMP_W'(tier_base[t]) + CMP_W'(tier_size[t]));
            if (hit[t]) begin
                sel_base = tier_base[t];
                sel_mask = tier_mask[t];
                sel_off  = tier_off[t];
            end
        end
        rel = {TB_W'(CMP_W'(chunk) - CMP_W'(sel_base)), in_addr[CHUNK_LG-1:LINE_LG]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s1_vld  <= 1'b0;
            s1_oor  <= 1'b0;
            s1_rel  <= '0;
            s1_mask <= '0;
            s1_off  <= '0;
            s1_nib  <= '0;
        end else begin
            s1_vld <= in_fire;
            if (in_fire) begin
                s1_oor  <= (hit == '0);
                s1_rel  <= rel;
                s1_mask <= sel_mask;
                s1_off  <= sel_off;
                s1_nib  <= in_addr[LINE_LG-1:0];
            end
        end
    end

    AST_ONE_TIER: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> $onehot0(hit)); // R4
endmodule

// File: rtl/ilv_line_split.sv
module ilv_line_split #(
    parameter int NSTK     = 4,
    parameter int CAP_W    = 8,
    parameter int SEL_W    = 2,
    parameter int REL_W    = 26,
    parameter int OFF_W    = 28,
    parameter int CHUNK_LG = 20,
    parameter int LINE_LG  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       s1_vld,
    input  logic                       s1_oor,
    input  logic [REL_W-1:0]           s1_rel,
    input  logic [NSTK-1:0]            s1_mask,
    input  logic [NSTK-1:0][CAP_W-1:0] s1_off,
    input  logic [LINE_LG-1:0]         s1_nib,
    output logic                       out_valid,
    output logic                       out_oor,
    output logic [SEL_W-1:0]           out_stack,
    output logic [OFF_W-1:0]           out_offset
);
    localparam int LL_W   = OFF_W - LINE_LG;
    localparam int SUB_LG = CHUNK_LG - LINE_LG;

    logic [NSTK-1:0][REL_W-1:0] quo, rmd;
    logic [SEL_W:0]             n_act;
    logic [SEL_W-1:0]           div_sel;
    logic [REL_W-1:0]           q_sel, r_sel;
    logic [SEL_W-1:0]           pick;
    logic [LL_W-1:0]            local_line;

    for (genvar k = 1; k <= NSTK; k++) begin : g_div
        assign quo[k-1] = s1_rel / REL_W'(k);
        assign rmd[k-1] = s1_rel % REL_W'(k);
    end

    always_comb begin
        n_act   = (SEL_W+1)'($countones(s1_mask));
        div_sel = (n_act == '0) ? '0 : SEL_W'(n_act - 1'b1);
        q_sel   = quo[div_sel];
        r_sel   = rmd[div_sel];
        pick    = '0;
        begin
            automatic int cnt = 0;
            for (int i = 0; i < NSTK; i++) begin
                if (s1_mask[i]) begin
                    if (r_sel == REL_W'(cnt)) pick = SEL_W'(i);
                    cnt++;
                end
            end
        end
        local_line = LL_W'({s1_off[pick], {SUB_LG{1'b0}}} + (CAP_W+SUB_LG+REL_W)'(q_sel));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid  <= 1'b0;
            out_oor    <= 1'b0;
            out_stack  <= '0;
            out_offset <= '0;
        end else begin
            out_valid <= s1_vld;
            if (s1_vld) begin
                out_oor    <= s1_oor;
                out_stack  <= s1_oor ? '0 : pick;
                out_offset <= s1_oor ? '0 : {local_line, s1_nib};
            end
        end
    end

    AST_PICK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld && !s1_oor |-> s1_mask[pick]); // R6
    AST_OOR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_oor |-> out_stack == '0 && out_offset == '0); // R7
endmodule

// File: rtl/stack_ilv_mapper.sv
module stack_ilv_mapper #(
    parameter int NSTK     = 4,
    parameter int CAP_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int CHUNK_LG = 20,
    parameter int LINE_LG  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_start,
    input  logic [NSTK*CAP_W-1:0]         cap_i,
    output logic                          cfg_done,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [ADDR_W-1:0]             in_addr,
    output logic                          out_valid,
    output logic [$clog2(NSTK)-1:0]       out_stack,
    output logic [CAP_W+CHUNK_LG-1:0]     out_offset,
    output logic                          out_oor
);
    localparam int SEL_W = $clog2(NSTK);
    localparam int TB_W  = CAP_W + SEL_W;
    localparam int REL_W = TB_W + CHUNK_LG - LINE_LG;
    localparam int OFF_W = CAP_W + CHUNK_LG;

    logic [NSTK-1:0][CAP_W-1:0]            cap_arr, cap_q;
    logic [NSTK-1:0]                       tier_vld;
    logic [NSTK-1:0][TB_W-1:0]             tier_base, tier_size;
    logic [NSTK-1:0][NSTK-1:0]             tier_mask;
    logic [NSTK-1:0][NSTK-1:0][CAP_W-1:0]  tier_off;
    logic                                  s1_vld, s1_oor, in_fire;
    logic [REL_W-1:0]                      s1_rel;
    logic [NSTK-1:0]                       s1_mask;
    logic [NSTK-1:0][CAP_W-1:0]            s1_off;
    logic [LINE_LG-1:0]                    s1_nib;

    for (genvar i = 0; i < NSTK; i++) begin : g_cap
        assign cap_arr[i] = cap_i[i*CAP_W +: CAP_W];
    end

    assign in_ready = cfg_done && !cfg_start;
    assign in_fire  = in_valid && in_ready;

    ilv_cfg_engine #(.NSTK(NSTK), .CAP_W(CAP_W), .SEL_W(SEL_W), .TB_W(TB_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cap_i(cap_arr),
        .cfg_done(cfg_done), .tier_vld(tier_vld), .tier_base(tier_base),
        .tier_size(tier_size), .tier_mask(tier_mask), .tier_off(tier_off),
        .cap_q(cap_q)
    );

    ilv_tier_lookup #(.NSTK(NSTK), .CAP_W(CAP_W), .TB_W(TB_W), .ADDR_W(ADDR_W),
                      .CHUNK_LG(CHUNK_LG), .LINE_LG(LINE_LG), .REL_W(REL_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .flush(cfg_start), .in_fire(in_fire),
        .in_addr(in_addr), .tier_vld(tier_vld), .tier_base(tier_base),
        .tier_size(tier_size), .tier_mask(tier_mask), .tier_off(tier_off),
        .s1_vld(s1_vld), .s1_oor(s1_oor), .s1_rel(s1_rel), .s1_mask(s1_mask),
        .s1_off(s1_off), .s1_nib(s1_nib)
    );

    ilv_line_split #(.NSTK(NSTK), .CAP_W(CAP_W), .SEL_W(SEL_W), .REL_W(REL_W),
                     .OFF_W(OFF_W), .CHUNK_LG(CHUNK_LG), .LINE_LG(LINE_LG)) u_split (
        .clk(clk), .rst_n(rst_n), .flush(cfg_start), .s1_vld(s1_vld),
        .s1_oor(s1_oor), .s1_rel(s1_rel), .s1_mask(s1_mask), .s1_off(s1_off),
        .s1_nib(s1_nib), .out_valid(out_valid), .out_oor(out_oor),
        .out_stack(out_stack), .out_offset(out_offset)
    );

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_fire, 2)); // R8
    AST_STACK_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_oor |-> cap_q[out_stack] != '0); // R6
    AST_OFFSET_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_oor |-> out_offset[OFF_W-1:CHUNK_LG] < cap_q[out_stack]); // R4
endmodule

// File: tb/stack_ilv_mapper_tb.sv
module stack_ilv_mapper_tb;
    localparam int NSTK = 4;

    logic        clk = 1'b0, rst_n = 1'b0, cfg_start = 1'b0, in_valid = 1'b0;
    logic [31:0] cap_i = '0, in_addr = '0;
    logic        cfg_done, in_ready, out_valid, out_oor;
    logic [1:0]  out_stack;
    logic [27:0] out_offset;

    int n_chk = 0, n_bad = 0;
    int caps[4];

    always #2.5 clk = ~clk;

    stack_ilv_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cap_i(cap_i),
        .cfg_done(cfg_done), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_stack(out_stack),
        .out_offset(out_offset), .out_oor(out_oor)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input longint a, output int stk,
                                  output longint off, output bit oor);
        int rem[4], used[4];
        longint base, chunk;
        rem = caps; used = '{0, 0, 0, 0}; base = 0; oor = 1; stk = 0; off = 0;
        chunk = a >> 20;
        for (int t = 0; t < 4; t++) begin
            int n, m;
            n = 0; m = 1 << 30;
            for (int i = 0; i < 4; i++) if (rem[i] > 0) begin n++; if (rem[i] < m) m = rem[i]; end
            if (n == 0) break;
            if (oor && chunk >= base && chunk < base + m * n) begin
                longint rel, q; int r, c;
                rel = (a >> 4) - base * 65536;
                r = int'(rel % n); q = rel / n; c = 0;
                for (int i = 0; i < 4; i++) if (rem[i] > 0) begin
                    if (c == r) stk = i;
                    c++;
                end
                off = ((longint'(used[stk]) * 65536 + q) << 4) | (a & 15);
                oor = 0;
            end
            for (int i = 0; i < 4; i++) if (rem[i] > 0) begin rem[i] -= m; used[i] += m; end
            base += m * n;
        end
    endfunction

    task automatic configure(int c0, int c1, int c2, int c3);
        int cyc;
        caps = '{c0, c1, c2, c3};
        cap_i = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R2 in_ready low while building", in_ready, 0);
        cyc = 0;
        while (!cfg_done && cyc < 10) begin
            @(negedge clk);
            cyc++;
        end
        chk("R2 cfg_done reached", cfg_done, 1);
        chk("R2 build cycles within bound", (cyc >= 1 && cyc <= NSTK), 1);
    endtask

    task automatic one(longint a, string req);
        int es; longint eo; bit eb;
        model(a, es, eo, eb);
        chk({req, " in_ready"}, in_ready, 1);
        in_valid = 1'b1; in_addr = 32'(a);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 no result after one edge", out_valid, 0);
        @(negedge clk);
        chk("R8 result after two edges", out_valid, 1);
        chk({req, " oor"}, out_oor, eb);
        chk({req, " stack"}, out_stack, es);
        chk({req, " offset"}, out_offset, eo);
    endtask

    task automatic direct(longint a, int es, longint eo, bit eb, string req);
        in_valid = 1'b1; in_addr = 32'(a);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, out_valid, 1);
        chk({req, " oor"}, out_oor, eb);
        chk({req, " stack"}, out_stack, es);
        chk({req, " offset"}, out_offset, eo);
    endtask

    task automatic burst(longint span);
        longint ad[8];
        for (int i = 0; i < 10; i++) begin
            if (i >= 2) begin
                int es; longint eo; bit eb;
                model(ad[i-2], es, eo, eb);
                chk("R8 stream valid", out_valid, 1);
                chk("R4 stream stack", out_stack, es);
                chk("R4 stream offset", out_offset, eo);
                chk("R7 stream oor", out_oor, eb);
            end
            if (i < 8) begin
                ad[i] = longint'($urandom) % span;
                in_valid = 1'b1; in_addr = 32'(ad[i]);
            end else in_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg_done", cfg_done, 0);
        chk("R1 in_ready", in_ready, 0);
        chk("R1 out_valid", out_valid, 0);

        in_valid = 1'b1; in_addr = 32'h40;
        repeat (3) begin
            @(negedge clk);
            chk("R2 request ignored before config", out_valid, 0);
        end
        in_valid = 1'b0;

        configure(64, 64, 64, 32);
        direct(64'h0,          0, 64'h0,          0, "R3 line0");
        direct(64'h10,         1, 64'h0,          0, "R3 line1");
        direct(64'h35,         3, 64'h5,          0, "R5 line3 nibble");
        direct(64'h4C,         0, 64'h1C,         0, "R3 line4");
        direct(64'h8000000,    0, 64'h2000000,    0, "R4 tier1 first");
        direct(64'h8000010,    1, 64'h2000000,    0, "R4 tier1 second");
        direct(64'h8000037,    0, 64'h2000017,    0, "R4 tier1 wrap");
        direct(64'hDFFFFF9,    2, 64'h3FFFFF9,    0, "R4 last line");
        direct(64'hE000000,    0, 64'h0,          1, "R7 at total");
        direct(64'hFFFFFFFF,   0, 64'h0,          1, "R7 top address");
        burst(64'hE400000);

        configure(0, 3, 0, 5);
        direct(64'h0,          1, 64'h0,          0, "R6 sparse line0");
        direct(64'h1A,         3, 64'hA,          0, "R6 sparse line1");
        direct(64'h600004,     3, 64'h300004,     0, "R6 sparse tier1");
        direct(64'h800000,     0, 64'h0,          1, "R7 sparse total");

        configure(0, 0, 0, 0);
        direct(64'h0,          0, 64'h0,          1, "R7 empty");

        configure(8, 8, 8, 8);
        in_valid = 1'b1; in_addr = 32'h30;
        @(negedge clk);
        in_valid = 1'b0; cap_i = {8'd4, 8'd0, 8'd0, 8'd0}; caps = '{0, 0, 0, 4};
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R9 in-flight dropped", out_valid, 0);
        chk("R9 cfg_done dropped", cfg_done, 0);
        repeat (3) @(negedge clk);
        chk("R9 rebuilt", cfg_done, 1);
        one(64'h30, "R9 new tiers");

        for (int k = 0; k < 5; k++) begin
            int c[4]; longint tot;
            for (int i = 0; i < 4; i++) c[i] = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 12));
            configure(c[0], c[1], c[2], c[3]);
            tot = longint'(c[0] + c[1] + c[2] + c[3]) << 20;
            for (int j = 0; j < 30; j++) one(longint'($urandom) % (tot + 64'h200000), "R4 random");
            burst(tot + 64'h100000);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule